// File: doc/BRIEF.md
# Keypad Digit Entry Collector

This block gathers a short hexadecimal code typed on a keypad. The keypad raises a data-available strobe while a key is held and presents the key's 4-bit value alongside it. The collector takes exactly one digit from each press and shifts it into an entry register, so the first digit typed ends up in the top nibble. Once the register holds the full number of digits, any further presses are dropped until the user presses OK.

A rising edge on the OK input closes the entry. The block then issues a one-cycle ready pulse, latches the assembled code onto its output, and raises a flag that shows whether the full digit count was reached. The same edge empties the entry for the next attempt. A surrounding controller can also empty the entry at any time with a synchronous clear, for example when it abandons an attempt. Inputs arrive already debounced, so the block applies no filtering.

Top module: `keycode_collector`

## Requirements
- R1: While reset is high and on the cycle after it is released, code_ready, code_complete and code_out are all 0.
- R2: A digit is captured only on a low-to-high transition of key_strobe. A key held high for many cycles yields exactly one digit.
- R3: After four digits are held, further key presses do not alter the entry. The code reported at the next OK is made of the first four digits.
- R4: Each new digit enters at bits 3:0 and earlier digits move up one nibble, so after four digits the first one sits in bits 15:12. When fewer digits were typed, they fill the low nibbles in typing order and the upper nibbles read 0 (A then B gives 16'h00AB).
- R5: A low-to-high transition of ok_press makes code_ready 1 for exactly one cycle, on the cycle after the edge. Holding ok_press high produces no further pulses.
- R6: code_complete, which is valid with the ready pulse, is 1 when exactly four digits were captured and 0 otherwise.
- R7: The OK edge also empties the entry, so the next attempt starts with no digits.
- R8: A cycle with clear high empties the entry. An OK that follows with no new digits reports code 0 with code_complete 0.
- R9: A key already held when reset is released is not captured. Only a later press counts.
- R10: A key edge in the same cycle as an OK edge is dropped. The OK reports the entry as it stood before that cycle.
- R11: code_out and code_complete change only on an OK edge. They hold their values while a new entry is being typed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_strobe | input | 1 | High while a keypad key is held |
| key_value | input | 4 | Hex value of the held key |
| ok_press | input | 1 | OK button level, high while pressed |
| clear | input | 1 | Synchronous entry clear from the controller |
| code_out | output | 16 | Code latched at the last OK, first digit in bits 15:12 |
| code_ready | output | 1 | One-cycle pulse after each OK edge |
| code_complete | output | 1 | Last reported code had exactly four digits |

## Verification
The bench holds keys and the OK button for several cycles. A design that captures on the level instead of the edge would fill the entry from one press, and one that pulses on the OK level would repeat code_ready. It types six digits and expects only the first four back. A collector that keeps shifting past the limit would report the last four digits instead. Short entries, clears, a key held across reset and a key edge that lands on the OK edge are each followed by an OK whose code and completeness flag show any leftover or misplaced digits. It also confirms that code_out stays unchanged while the next entry is typed, which catches a design that drives the output straight from the live entry.

// File: rtl/keyentry_pkg.sv
package keyentry_pkg;
  localparam int unsigned KE_DIGIT_W    = 4;
  localparam int unsigned KE_NUM_DIGITS = 4;

  function automatic int unsigned ke_count_w(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/ke_edge.sv
module ke_edge (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise
);
  logic level_q;

  // The level is sampled during reset as well, so an input already high at
  // release shows no edge (R9).
  always_ff @(posedge clk) begin
    level_q <= level;
  end

  assign rise = level & ~level_q & ~rst;

  // R2/R5: an edge cannot repeat on the next cycle
  p_rise_single_r2: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/ke_tally.sv
module ke_tally #(
  parameter int unsigned NUM_DIGITS = 4,
  localparam int unsigned CW = $clog2(NUM_DIGITS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count,
  output logic          full
);
  localparam logic [CW-1:0] LIMIT = CW'(NUM_DIGITS);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (inc && !full) begin
      count <= count + 1'b1;
    end
  end

  assign full = (count == LIMIT);

  // R3: the count never passes the digit limit
  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    count <= LIMIT);
  // R3: once full, only a clear can empty it
  p_full_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (full && !clr) |=> full);
  // R2: without an increment or clear the count stays put
  p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!inc && !clr) |=> $stable(count));
endmodule

// File: rtl/ke_shift.sv
module ke_shift #(
  parameter int unsigned DIGIT_W    = 4,
  parameter int unsigned NUM_DIGITS = 4,
  localparam int unsigned CODE_W = DIGIT_W * NUM_DIGITS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               shift_en,
  input  logic [DIGIT_W-1:0] din,
  output logic [CODE_W-1:0]  code
);
  logic [DIGIT_W-1:0] slot [NUM_DIGITS];

  // slot[0] holds the newest digit; older digits move toward the top (R4)
  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        slot[i] <= '0;
      end else if (shift_en) begin
        if (i == 0) slot[i] <= din;
        else        slot[i] <= slot[(i == 0) ? 0 : i - 1];
      end
    end
    assign code[i*DIGIT_W +: DIGIT_W] = slot[i];
  end

  // R4: a shifted digit lands in the lowest nibble
  p_low_nibble_r4: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !clr) |=> code[DIGIT_W-1:0] == $past(din));
  // R3: with no shift and no clear the entry is frozen
  p_entry_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !clr) |=> $stable(code));
endmodule

// File: rtl/keycode_collector.sv
module keycode_collector
  import keyentry_pkg::*;
#(
  parameter int unsigned DIGIT_W    = KE_DIGIT_W,
  parameter int unsigned NUM_DIGITS = KE_NUM_DIGITS,
  localparam int unsigned CODE_W = DIGIT_W * NUM_DIGITS,
  localparam int unsigned CW     = $clog2(NUM_DIGITS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               key_strobe,
  input  logic [DIGIT_W-1:0] key_value,
  input  logic               ok_press,
  input  logic               clear,
  output logic [CODE_W-1:0]  code_out,
  output logic               code_ready,
  output logic               code_complete
);
  logic          key_rise;
  logic          ok_rise;
  logic          accept;
  logic          entry_clr;
  logic          full;
  logic [CW-1:0] count;
  logic [CODE_W-1:0] entry;

  ke_edge u_key_edge (.clk(clk), .rst(rst), .level(key_strobe), .rise(key_rise));
  ke_edge u_ok_edge  (.clk(clk), .rst(rst), .level(ok_press),   .rise(ok_rise));

  // OK outranks a simultaneous key edge (R10); clear empties the entry (R8)
  assign entry_clr = clear | ok_rise;
  assign accept    = key_rise & ~full & ~entry_clr;

  ke_tally #(.NUM_DIGITS(NUM_DIGITS)) u_tally (
    .clk(clk), .rst(rst), .clr(entry_clr), .inc(accept),
    .count(count), .full(full)
  );

  ke_shift #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS)) u_shift (
    .clk(clk), .rst(rst), .clr(entry_clr), .shift_en(accept),
    .din(key_value), .code(entry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code_out      <= '0;
      code_ready    <= 1'b0;
      code_complete <= 1'b0;
    end else begin
      code_ready <= ok_rise;
      if (ok_rise) begin
        code_out      <= entry;
        code_complete <= (count == CW'(NUM_DIGITS));
      end
    end
  end

  // R5: the ready pulse lasts a single cycle
  p_ready_once_r5: assert property (@(posedge clk) disable iff (rst)
    code_ready |=> !code_ready);
  // R5: every OK edge is answered by a ready pulse
  p_ok_answer_r5: assert property (@(posedge clk) disable iff (rst)
    ok_rise |=> code_ready);
  // R11: outputs move only on an OK edge
  p_out_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !ok_rise |=> ($stable(code_out) && $stable(code_complete)));
  // R7: the entry is empty after an OK edge
  p_restart_r7: assert property (@(posedge clk) disable iff (rst)
    ok_rise |=> (entry == '0));
endmodule

// File: tb/test_keycode_collector.sv
module test_keycode_collector;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        key_strobe = 1'b0;
  logic [3:0]  key_value = 4'h0;
  logic        ok_press = 1'b0;
  logic        clear = 1'b0;
  logic [15:0] code_out;
  logic        code_ready;
  logic        code_complete;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  keycode_collector i_keycode_collector (
    .clk(clk), .rst(rst), .key_strobe(key_strobe), .key_value(key_value),
    .ok_press(ok_press), .clear(clear), .code_out(code_out),
    .code_ready(code_ready), .code_complete(code_complete)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic press_key(input logic [3:0] v, input int hold);
    @(negedge clk);
    key_value  = v;
    key_strobe = 1'b1;
    repeat (hold) @(negedge clk);
    key_strobe = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Press OK, hold it several cycles, check the pulse and the reported code
  task automatic press_ok(input logic [15:0] exp_code, input bit exp_full,
                          input string req);
    @(negedge clk);
    ok_press = 1'b1;
    @(negedge clk);
    check(code_ready === 1'b1, {req, " ready pulse"}, 32'(code_ready), 32'd1);
    check(code_out === exp_code, {req, " code"}, 32'(code_out), 32'(exp_code));
    check(code_complete === exp_full, {req, " complete"}, 32'(code_complete),
          32'(exp_full));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(code_ready === 1'b0, "R5 single pulse while held", 32'(code_ready), 32'd0);
    end
    ok_press = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(code_out === 16'h0 && code_ready === 1'b0 && code_complete === 1'b0,
          "R1 in reset", {13'h0, code_ready, code_complete, 1'b0, code_out}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(code_out === 16'h0 && code_ready === 1'b0 && code_complete === 1'b0,
          "R1 after release", {13'h0, code_ready, code_complete, 1'b0, code_out}, 32'h0);
  endtask

  task automatic t_four_digits;  // R2, R4, R6: long holds, one digit each
    press_key(4'h1, 8);
    press_key(4'hA, 1);
    press_key(4'h3, 12);
    press_key(4'hF, 3);
    press_ok(16'h1A3F, 1'b1, "R4 R6 four digits");
  endtask

  task automatic t_overflow;  // R3, R7
    press_key(4'h9, 2);
    press_key(4'h8, 2);
    press_key(4'h7, 2);
    press_key(4'h6, 2);
    press_key(4'h5, 2);
    press_key(4'h4, 2);
    press_ok(16'h9876, 1'b1, "R3 extra digits ignored");
  endtask

  task automatic t_short;  // R4, R6, R7, R11
    press_key(4'hA, 2);
    check(code_out === 16'h9876, "R11 hold during entry", 32'(code_out), 32'h9876);
    press_key(4'hB, 2);
    check(code_complete === 1'b1, "R11 complete held", 32'(code_complete), 32'd1);
    press_ok(16'h00AB, 1'b0, "R4 R7 two digits");
  endtask

  task automatic t_clear;  // R8
    press_key(4'h2, 2);
    press_key(4'h5, 2);
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    press_ok(16'h0000, 1'b0, "R8 clear empties");
    press_key(4'hC, 2);
    press_ok(16'h000C, 1'b0, "R8 entry after clear");
  endtask

  task automatic t_held_at_reset;  // R9
    @(negedge clk);
    rst = 1'b1;
    key_value = 4'hE;
    key_strobe = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    key_strobe = 1'b0;
    repeat (2) @(negedge clk);
    press_ok(16'h0000, 1'b0, "R9 held key at reset");
  endtask

  task automatic t_collision;  // R10
    press_key(4'h4, 2);
    @(negedge clk);
    key_value = 4'hD;
    key_strobe = 1'b1;
    ok_press = 1'b1;
    @(negedge clk);
    check(code_ready === 1'b1, "R10 ready", 32'(code_ready), 32'd1);
    check(code_out === 16'h0004, "R10 key dropped", 32'(code_out), 32'h4);
    key_strobe = 1'b0;
    ok_press = 1'b0;
    repeat (2) @(negedge clk);
    press_ok(16'h0000, 1'b0, "R10 nothing left over");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_four_digits();
    t_overflow();
    t_short();
    t_clear();
    t_held_at_reset();
    t_collision();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule